// File: doc/BRIEF.md
# Dual-Converter Scan Sequencer

This block schedules one scan over up to eight sample slots for a pair of analog-to-digital converters. Each slot has an input pin and can be turned off. Off slots are passed over and add no time. In sequential form the slots convert one at a time on converter A. In simultaneous form, slots 2k and 2k+1 form pair k: converter A takes the even slot and converter B takes the odd slot, both in the same conversion period. The analog path is a stub. At each conversion command it latches the 12-bit value offered for the selected pin, and the sequencer writes that value into the slot's result register when the conversion period ends.

One clock cycle of `clk_i` is one half-cycle of the converter clock, so every timing figure below is a count of `clk_i` edges. A write to the configuration loads the mode, the slot-off mask and the pin map. This write also stops any activity, arms once mode and clears the sticky flags. A software start pulse or a timer sync pulse triggers a scan. The stop pulse ends activity. Result registers have no second buffer, so each write replaces the previous value of that slot.

Top module: `adc_scan_seq`

## Requirements
- R1: Mode field `cfg_mode_i` encodings: 000 once-sequential, 001 once-simultaneous, 010 loop-sequential, 011 loop-simultaneous, 100 triggered-sequential, 101 triggered-simultaneous. Bit 0 selects simultaneous. The codes 110 and 111 are reserved: with them, triggers are ignored and `busy_o` stays low.
- R2: After an accepted trigger, the first result write of a scan takes place 17 edges after the edge that sampled the trigger. Each further conversion unit adds 12 edges. Off slots add nothing. Four sequential slots therefore end 53 edges after the trigger.
- R3: A slot's result register, at bits [12s+11:12s] of `res_o`, receives the `ain_i` word of its mapped pin, at bits [12p+11:12p]. Slots that are off keep their old value. No result is written within the first 12 edges of a scan.
- R4: In simultaneous form, pair k (slots 2k and 2k+1) uses one conversion period. Both of its enabled slots are written at the same edge.
- R5: A simultaneous pair whose two enabled slots map to the same pin is invalid. It is skipped and takes no time. Accepting a trigger while such a pair exists sets `pair_err_o`, which stays set until the next configuration write.
- R6: Once mode runs one scan per arming. A configuration write arms it again. A configuration write also aborts any scan in progress, and `busy_o` is low after the write.
- R7: Triggered mode runs a full scan on every `start_i` or `sync_i` received while idle. Each of these scans pays the full 17-edge first period.
- R8: Loop mode repeats the scan without any trigger. Only the first conversion after the start takes 17 edges. Every later conversion, including the first one of each repeated scan, takes 12. `stop_i` ends the loop at the next edge, and no result is written after that.
- R9: At the end of a scan, `eos_o` is set and stays set until a configuration write. In once and triggered modes, `irq_o` pulses for one cycle at the edge of the last write of the scan. In loop mode `irq_o` never rises.
- R10: A trigger that arrives while the sequencer is busy is ignored. It sets `ovr_o`, which stays set until a configuration write.
- R11: A trigger that arrives when no conversion unit is enabled starts no scan.
- R12: After reset, all outputs are low, all results are zero and the mode is reserved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one period is half a converter clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_mode_i | input | 3 | Scan mode code |
| cfg_dis_i | input | NUM_SLOTS | Slot-off mask, bit s for slot s |
| cfg_pins_i | input | NUM_SLOTS*PIN_W | Pin number per slot, slot s at bits [PIN_W*s+PIN_W-1:PIN_W*s] |
| start_i | input | 1 | Software start pulse |
| sync_i | input | 1 | Timer sync pulse |
| stop_i | input | 1 | Stop pulse |
| ain_i | input | (2**PIN_W)*DATA_W | Stub sample value per pin |
| res_o | output | NUM_SLOTS*DATA_W | Result registers, slot s at bits [DATA_W*s+DATA_W-1:DATA_W*s] |
| busy_o | output | 1 | A scan or loop is active |
| irq_o | output | 1 | End-of-scan interrupt pulse |
| eos_o | output | 1 | Sticky end-of-scan status |
| ovr_o | output | 1 | Sticky trigger overrun |
| pair_err_o | output | 1 | Sticky invalid-pair flag |

## Verification
The bench measures the number of edges from the trigger to the interrupt. A design that refilled the pipeline in the wrong modes, or charged time for off slots or invalid pairs, would report 17 or 12 edges away from the model. In loop mode the bench changes a pin value between two scans and finds the exact edge where the new value appears. A loop that refilled on every scan would show the update five edges late. A stop that failed to stop would keep overwriting results. Further checks cover: a second start in once mode, reserved codes, a trigger with nothing enabled, and a trigger while busy. Results under each of these must stay unchanged, and `irq_o` must stay low whenever no scan should end.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    KIND_ONCE = 2'd0,
    KIND_LOOP = 2'd1,
    KIND_TRIG = 2'd2,
    KIND_RSVD = 2'd3
  } scan_kind_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/adc_unit_map.sv
module adc_unit_map #(
  parameter int NUM_SLOTS = 8,
  parameter int PIN_W     = 3
) (
  input  logic                       simul_i,
  input  logic [NUM_SLOTS-1:0]       dis_i,
  input  logic [NUM_SLOTS*PIN_W-1:0] pins_i,
  output logic [NUM_SLOTS-1:0]       unit_en_o,
  output logic [NUM_SLOTS-1:0]       slot_ok_o,
  output logic                       bad_o
);
  localparam int NUM_PAIRS = NUM_SLOTS / 2;

  logic [NUM_PAIRS-1:0] pair_en, pair_bad;
  logic [NUM_SLOTS-1:0] sim_ok;

  for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair
    logic en_a, en_b, same;
    assign en_a        = ~dis_i[2*k];
    assign en_b        = ~dis_i[2*k+1];
    assign same        = pins_i[2*k*PIN_W +: PIN_W] == pins_i[(2*k+1)*PIN_W +: PIN_W];
    assign pair_bad[k] = en_a & en_b & same;
    assign pair_en[k]  = (en_a | en_b) & ~pair_bad[k];
    assign sim_ok[2*k]   = en_a & ~pair_bad[k];
    assign sim_ok[2*k+1] = en_b & ~pair_bad[k];
  end

  assign unit_en_o = simul_i ? {{(NUM_SLOTS-NUM_PAIRS){1'b0}}, pair_en} : ~dis_i;
  assign slot_ok_o = simul_i ? sim_ok : ~dis_i;
  assign bad_o     = simul_i & (|pair_bad);
endmodule

// File: rtl/adc_unit_pick.sv
module adc_unit_pick #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     mask_i,
  input  logic [IDX_W:0]   from_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  // lowest enabled unit at or above from_i
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (mask_i[i] && (i >= int'(from_i))) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/adc_conv_stub.sv
module adc_conv_stub #(
  parameter int PIN_W  = 3,
  parameter int DATA_W = 12
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           load_i,
  input  logic [PIN_W-1:0]               pin_i,
  input  logic [(2**PIN_W)*DATA_W-1:0]   ain_i,
  output logic [DATA_W-1:0]              data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     data_o <= '0;
    else if (load_i) data_o <= ain_i[int'(pin_i)*DATA_W +: DATA_W];
  end
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
  parameter int NUM_SLOTS = 8,
  parameter int DATA_W    = 12,
  parameter int UNIT_W    = $clog2(NUM_SLOTS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_i,
  input  logic                        simul_i,
  input  logic [UNIT_W-1:0]           unit_i,
  input  logic [NUM_SLOTS-1:0]        slot_ok_i,
  input  logic [DATA_W-1:0]           data_a_i,
  input  logic [DATA_W-1:0]           data_b_i,
  output logic [NUM_SLOTS*DATA_W-1:0] res_o,
  output logic [NUM_SLOTS-1:0]        we_o
);
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic hit;
    logic [DATA_W-1:0] res_q;
    assign hit     = simul_i ? (unit_i == UNIT_W'(s / 2)) : (unit_i == UNIT_W'(s));
    assign we_o[s] = wr_i & hit & slot_ok_i[s];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      res_q <= '0;
      else if (we_o[s]) res_q <= (simul_i && (s % 2 == 1)) ? data_b_i : data_a_i;
    end
    assign res_o[s*DATA_W +: DATA_W] = res_q;
  end
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_seq_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int PIN_W     = 3,
  parameter int DATA_W    = 12,
  parameter int FILL_HT   = 17,
  parameter int NEXT_HT   = 12
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           cfg_we_i,
  input  logic [2:0]                     cfg_mode_i,
  input  logic [NUM_SLOTS-1:0]           cfg_dis_i,
  input  logic [NUM_SLOTS*PIN_W-1:0]     cfg_pins_i,
  input  logic                           start_i,
  input  logic                           sync_i,
  input  logic                           stop_i,
  input  logic [(2**PIN_W)*DATA_W-1:0]   ain_i,
  output logic [NUM_SLOTS*DATA_W-1:0]    res_o,
  output logic                           busy_o,
  output logic                           irq_o,
  output logic                           eos_o,
  output logic                           ovr_o,
  output logic                           pair_err_o
);
  localparam int UNIT_W = $clog2(NUM_SLOTS);
  localparam int CNT_W  = $clog2(FILL_HT + 1);

  seq_state_e                 state_q;
  scan_kind_e                 kind_q;
  logic                       simul_q;
  logic [NUM_SLOTS-1:0]       dis_q;
  logic [NUM_SLOTS*PIN_W-1:0] pins_q;
  logic                       armed_q;
  logic [UNIT_W-1:0]          unit_q;
  logic [CNT_W-1:0]           cnt_q;
  logic                       irq_q, eos_q, ovr_q, perr_q;

  logic [NUM_SLOTS-1:0] unit_en, slot_ok, res_we;
  logic                 bad_any, trig, can_start, done_conv;
  logic                 f_found, n_found;
  logic [UNIT_W-1:0]    f_idx, n_idx, ld_unit;
  logic                 ld_en;
  logic [UNIT_W-1:0]    ld_slot [2];
  logic [PIN_W-1:0]     ld_pin  [2];
  logic [DATA_W-1:0]    cv_data [2];

  adc_unit_map #(.NUM_SLOTS(NUM_SLOTS), .PIN_W(PIN_W)) u_map (
    .simul_i(simul_q), .dis_i(dis_q), .pins_i(pins_q),
    .unit_en_o(unit_en), .slot_ok_o(slot_ok), .bad_o(bad_any)
  );

  adc_unit_pick #(.N(NUM_SLOTS)) u_first (
    .mask_i(unit_en), .from_i('0), .found_o(f_found), .idx_o(f_idx)
  );

  adc_unit_pick #(.N(NUM_SLOTS)) u_next (
    .mask_i(unit_en), .from_i({1'b0, unit_q} + 1'b1), .found_o(n_found), .idx_o(n_idx)
  );

  assign trig      = start_i | sync_i;
  assign can_start = (kind_q != KIND_RSVD) && (kind_q != KIND_ONCE || armed_q) && f_found;
  assign done_conv = (state_q == ST_RUN) && (cnt_q == '0);

  // conversion command: new unit enters the converters
  always_comb begin
    ld_en   = 1'b0;
    ld_unit = f_idx;
    if (!cfg_we_i && !stop_i) begin
      if (state_q == ST_IDLE) begin
        ld_en = trig && can_start;
      end else if (done_conv) begin
        if (n_found) begin
          ld_en   = 1'b1;
          ld_unit = n_idx;
        end else if (kind_q == KIND_LOOP) begin
          ld_en = 1'b1;
        end
      end
    end
  end

  assign ld_slot[0] = simul_q ? {ld_unit[UNIT_W-2:0], 1'b0} : ld_unit;
  assign ld_slot[1] = {ld_unit[UNIT_W-2:0], 1'b1};

  for (genvar c = 0; c < 2; c++) begin : g_conv
    assign ld_pin[c] = pins_q[int'(ld_slot[c])*PIN_W +: PIN_W];
    adc_conv_stub #(.PIN_W(PIN_W), .DATA_W(DATA_W)) u_stub (
      .clk_i(clk_i), .rst_ni(rst_ni), .load_i(ld_en),
      .pin_i(ld_pin[c]), .ain_i(ain_i), .data_o(cv_data[c])
    );
  end

  adc_result_bank #(.NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_i(done_conv & ~cfg_we_i & ~stop_i),
    .simul_i(simul_q), .unit_i(unit_q), .slot_ok_i(slot_ok),
    .data_a_i(cv_data[0]), .data_b_i(cv_data[1]),
    .res_o(res_o), .we_o(res_we)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      kind_q  <= KIND_RSVD;
      simul_q <= 1'b0;
      dis_q   <= '1;
      pins_q  <= '0;
      armed_q <= 1'b0;
      unit_q  <= '0;
      cnt_q   <= '0;
      irq_q   <= 1'b0;
      eos_q   <= 1'b0;
      ovr_q   <= 1'b0;
      perr_q  <= 1'b0;
    end else if (cfg_we_i) begin
      state_q <= ST_IDLE;
      kind_q  <= scan_kind_e'(cfg_mode_i[2:1]);
      simul_q <= cfg_mode_i[0];
      dis_q   <= cfg_dis_i;
      pins_q  <= cfg_pins_i;
      armed_q <= 1'b1;
      irq_q   <= 1'b0;
      eos_q   <= 1'b0;
      ovr_q   <= 1'b0;
      perr_q  <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (stop_i) begin
        state_q <= ST_IDLE;
      end else if (state_q == ST_IDLE) begin
        if (trig && can_start) begin
          state_q <= ST_RUN;
          unit_q  <= f_idx;
          cnt_q   <= CNT_W'(FILL_HT - 1);
          armed_q <= 1'b0;
          if (bad_any) perr_q <= 1'b1;
        end
      end else begin
        if (trig) ovr_q <= 1'b1;
        if (cnt_q != '0) begin
          cnt_q <= cnt_q - 1'b1;
        end else if (n_found) begin
          unit_q <= n_idx;
          cnt_q  <= CNT_W'(NEXT_HT - 1);
        end else begin
          eos_q <= 1'b1;
          if (kind_q == KIND_LOOP) begin
            // pipeline stays full across loop scans
            unit_q <= f_idx;
            cnt_q  <= CNT_W'(NEXT_HT - 1);
          end else begin
            state_q <= ST_IDLE;
            irq_q   <= 1'b1;
          end
        end
      end
    end
  end

  assign busy_o     = (state_q == ST_RUN);
  assign irq_o      = irq_q;
  assign eos_o      = eos_q;
  assign ovr_o      = ovr_q;
  assign pair_err_o = perr_q;
endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
  parameter int NUM_SLOTS = 8,
  parameter int NEXT_HT   = 12
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 cfg_we_i,
  input logic                 stop_i,
  input logic                 busy_i,
  input logic                 irq_i,
  input logic                 eos_i,
  input logic                 ovr_i,
  input logic [1:0]           kind_i,
  input logic [NUM_SLOTS-1:0] res_we_i
);
  localparam logic [7:0] MIN_GAP = 8'(NEXT_HT - 1);

  logic [7:0] since_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         since_q <= '0;
    else if (!busy_i)    since_q <= '0;
    else if (since_q != 8'hFF) since_q <= since_q + 8'd1;
  end

  a_r1_reserved_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kind_i == 2'd3 |-> !busy_i);
  a_r3_no_early_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|res_we_i) |-> since_q >= MIN_GAP);
  a_r6_cfg_aborts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> !busy_i);
  a_r8_stop_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !busy_i);
  a_r9_no_irq_in_loop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> kind_i != 2'd1);
  a_r9_irq_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> (!busy_i && eos_i));
  a_r9_irq_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |=> !irq_i);
  a_r10_ovr_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_i && !cfg_we_i) |=> ovr_i);
endmodule

bind adc_scan_seq adc_scan_seq_chk #(.NUM_SLOTS(NUM_SLOTS), .NEXT_HT(NEXT_HT)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .stop_i(stop_i),
  .busy_i(busy_o), .irq_i(irq_o), .eos_i(eos_o), .ovr_i(ovr_o),
  .kind_i(kind_q), .res_we_i(res_we)
);

// File: tb/adc_scan_seq_bench.sv
module adc_scan_seq_bench;
  localparam int NS = 8;
  localparam int PW = 3;
  localparam int DW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_mode = 3'b110;
  logic [NS-1:0] cfg_dis = '1;
  logic [NS*PW-1:0] cfg_pins;
  logic start = 1'b0, sync = 1'b0, stop = 1'b0;
  logic [8*DW-1:0] ain_flat;
  logic [NS*DW-1:0] res;
  logic busy, irq, eos, ovr, perr;

  logic [DW-1:0] ain [8];
  logic [PW-1:0] cur_pins [NS];
  logic [NS-1:0] cur_dis;
  logic          cur_simul;
  logic [DW-1:0] exp_res [NS];

  int checks = 0, fails = 0;
  int cyc = 0, t0 = 0, tp = 0;
  bit irq_seen;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always_comb begin
    for (int p = 0; p < 8; p++) ain_flat[p*DW +: DW] = ain[p];
    for (int s = 0; s < NS; s++) cfg_pins[s*PW +: PW] = cur_pins[s];
  end

  adc_scan_seq u_adc_scan_seq (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_mode_i(cfg_mode),
    .cfg_dis_i(cfg_dis), .cfg_pins_i(cfg_pins), .start_i(start), .sync_i(sync),
    .stop_i(stop), .ain_i(ain_flat), .res_o(res), .busy_o(busy), .irq_o(irq),
    .eos_o(eos), .ovr_o(ovr), .pair_err_o(perr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit pair_bad(int k);
    return !cur_dis[2*k] && !cur_dis[2*k+1] && (cur_pins[2*k] == cur_pins[2*k+1]);
  endfunction

  function automatic int units();
    int n = 0;
    if (!cur_simul) begin
      for (int s = 0; s < NS; s++) if (!cur_dis[s]) n++;
    end else begin
      for (int k = 0; k < NS/2; k++)
        if ((!cur_dis[2*k] || !cur_dis[2*k+1]) && !pair_bad(k)) n++;
    end
    return n;
  endfunction

  function automatic bit written(int s);
    if (!cur_simul) return !cur_dis[s];
    return !cur_dis[s] && !pair_bad(s/2);
  endfunction

  function automatic int scan_len(int n);
    return 17 + 12 * (n - 1);
  endfunction

  task automatic set_cfg(input logic [2:0] mode, input logic [NS-1:0] dis);
    @(negedge clk);
    cfg_we = 1'b1; cfg_mode = mode; cfg_dis = dis;
    cur_simul = mode[0]; cur_dis = dis;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse(input bit use_sync);
    @(negedge clk);
    if (use_sync) sync = 1'b1; else start = 1'b1;
    @(posedge clk); #1;
    tp = cyc; start = 1'b0; sync = 1'b0;
    irq_seen = irq;
  endtask

  task automatic to_cyc(input int k);
    while (cyc - t0 < k) begin
      @(posedge clk); #1;
      irq_seen |= irq;
    end
  endtask

  task automatic wait_irq(output int dur);
    dur = -1;
    for (int n = 0; n < 400; n++) begin
      @(posedge clk); #1;
      if (irq) begin dur = cyc - t0; break; end
    end
  endtask

  task automatic check_res(input string req);
    for (int s = 0; s < NS; s++) chk(req, res[s*DW +: DW], exp_res[s]);
  endtask

  task automatic update_exp();
    for (int s = 0; s < NS; s++) if (written(s)) exp_res[s] = ain[cur_pins[s]];
  endtask

  // one scan in once/triggered mode against the model
  task automatic do_scan(input string req, input bit use_sync);
    int n, dur;
    n = units();
    pulse(use_sync); t0 = tp;
    if (n == 0) begin
      chk({req, " R11 busy"}, busy, 0);
      to_cyc(40);
      chk({req, " R11 irq"}, irq_seen, 0);
    end else begin
      wait_irq(dur);
      chk({req, " R2 duration"}, dur, scan_len(n));
      update_exp();
      chk({req, " R9 eos"}, eos, 1);
    end
    check_res({req, " R3 results"});
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int dur;
    logic [DW-1:0] old_v;
    void'($urandom(32'd20240611));
    for (int p = 0; p < 8; p++) ain[p] = DW'(100 + 37 * p);
    for (int s = 0; s < NS; s++) begin cur_pins[s] = PW'(s); exp_res[s] = '0; end
    cur_dis = '1; cur_simul = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R12 reset state
    chk("R12 busy", busy, 0);
    chk("R12 irq", irq, 0);
    chk("R12 flags", {eos, ovr, perr}, 0);
    check_res("R12 results");

    // R1 reserved mode before any config and after 111
    pulse(0);
    chk("R1 reserved busy", busy, 0);
    set_cfg(3'b111, 8'h00);
    pulse(0); t0 = tp;
    to_cyc(30);
    chk("R1 reserved no irq", irq_seen, 0);
    chk("R1 reserved busy", busy, 0);
    check_res("R1 results untouched");

    // R2 R7 triggered sequential, four slots
    cur_pins = '{3'd5, 3'd2, 3'd7, 3'd0, 3'd1, 3'd1, 3'd4, 3'd6};
    set_cfg(3'b100, 8'hF0);
    do_scan("R7 start", 0);
    for (int p = 0; p < 8; p++) ain[p] = ain[p] + 12'd9;
    do_scan("R7 sync refill", 1);

    // R10 overrun during a scan
    pulse(0); t0 = tp;
    to_cyc(5);
    pulse(1);
    wait_irq(dur);
    chk("R10 duration unchanged", dur, 53);
    chk("R10 ovr set", ovr, 1);
    set_cfg(3'b100, 8'hF0);
    chk("R10 ovr cleared", ovr, 0);

    // R4 simultaneous pairs
    cur_pins = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7};
    for (int p = 0; p < 8; p++) ain[p] = DW'(1000 + 11 * p);
    set_cfg(3'b101, 8'h00);
    do_scan("R4 four pairs", 0);
    for (int p = 0; p < 8; p++) ain[p] = ain[p] ^ 12'h0F0;
    set_cfg(3'b101, 8'b0010_0000);
    do_scan("R4 half pair", 0);

    // R5 invalid pair skipped
    cur_pins[2] = 3'd4; cur_pins[3] = 3'd4;
    for (int p = 0; p < 8; p++) ain[p] = ain[p] + 12'd3;
    set_cfg(3'b101, 8'h00);
    chk("R5 pair_err clear", perr, 0);
    do_scan("R5 bad pair", 0);
    chk("R5 pair_err set", perr, 1);
    chk("R5 three pairs", units(), 3);

    // R6 once mode
    cur_pins = '{3'd6, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0, 3'd7};
    set_cfg(3'b000, 8'hE8);
    do_scan("R6 once first", 0);
    for (int p = 0; p < 8; p++) ain[p] = ain[p] + 12'd50;
    pulse(0); t0 = tp;
    chk("R6 once not rearmed", busy, 0);
    to_cyc(80);
    chk("R6 no second irq", irq_seen, 0);
    check_res("R6 results kept");
    set_cfg(3'b000, 8'hE8);
    do_scan("R6 rearmed", 1);

    // R6 configuration write aborts a scan
    set_cfg(3'b100, 8'h00);
    for (int p = 0; p < 8; p++) ain[p] = ain[p] + 12'd1;
    pulse(0); t0 = tp;
    to_cyc(20);
    exp_res[0] = ain[cur_pins[0]];
    set_cfg(3'b100, 8'h00);
    chk("R6 abort busy", busy, 0);
    to_cyc(60);
    check_res("R6 abort results");

    // R8 R9 loop mode, slots 0 and 1
    cur_pins[0] = 3'd3; cur_pins[1] = 3'd5;
    ain[3] = 12'd111; ain[5] = 12'd222;
    set_cfg(3'b010, 8'hFC);
    pulse(0); t0 = tp;
    to_cyc(17);
    chk("R8 loop first fill", res[0 +: DW], 111);
    old_v = 12'd111;
    ain[3] = 12'd333;
    to_cyc(28);
    chk("R9 eos before end", eos, 0);
    to_cyc(29);
    chk("R9 loop eos", eos, 1);
    chk("R3 loop slot1", res[DW +: DW], 222);
    to_cyc(40);
    chk("R8 no refill early", res[0 +: DW], old_v);
    to_cyc(41);
    chk("R8 no refill update", res[0 +: DW], 333);
    to_cyc(120);
    chk("R9 loop no irq", irq_seen, 0);
    chk("R8 still busy", busy, 1);
    @(negedge clk); stop = 1'b1;
    @(posedge clk); #1; stop = 1'b0;
    chk("R8 stop idle", busy, 0);
    old_v = res[0 +: DW];
    ain[3] = 12'd444; ain[5] = 12'd555;
    repeat (60) @(posedge clk); #1;
    chk("R8 stop no write", res[0 +: DW], old_v);
    exp_res[0] = res[0 +: DW]; exp_res[1] = res[DW +: DW];

    // R11 nothing enabled
    set_cfg(3'b100, 8'hFF);
    do_scan("R11 empty", 0);

    // random triggered scans
    for (int it = 0; it < 24; it++) begin
      logic [NS-1:0] d;
      logic [2:0] m;
      d = NS'($urandom & $urandom);
      m = ($urandom % 2) ? 3'b101 : 3'b100;
      for (int s = 0; s < NS; s++) cur_pins[s] = PW'($urandom);
      for (int p = 0; p < 8; p++) ain[p] = DW'($urandom);
      set_cfg(m, d);
      do_scan("R2 random", ($urandom % 2) == 1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule